// File: doc/BRIEF.md
# Dual-Mode Serial Command Receiver

This block is the serial front end on the panel side of a display controller. A static strap picks one of two framings. In the four-wire framing, each byte is eight bits long, and a separate select pin marks it as a command or as data. In the three-wire framing, each frame is nine bits long, and its first bit carries that mark. The clock, data, chip-select and command/data pins each pass through a two-flop synchronizer into the system clock, which must run at least four times faster than the serial clock. Every completed byte appears as a one-cycle strobe with its command/data tag.

The block also serves reads. The host logic inspects each command byte while its strobe is high and states whether that command reads a register. After such a command, a read phase starts in one of two ways: in four-wire framing, the command/data pin goes high; in three-wire framing, a flag bit of 1 is clocked in. During the read phase the block requests bytes from the host logic and shifts them out MSB first, updating on falling serial clock edges. The phase ends when chip select goes high.

Top module: `serial_cmd_rx`

## Requirements
- R1: After reset, rx_valid, rd_req and sdo_oe are all 0.
- R2: With three_wire = 0, eight bits are sampled MSB first on rising sclk edges. The byte is then emitted with rx_is_data equal to the dc pin level (0 = command, 1 = data).
- R3: With three_wire = 1, a frame is nine bits long. The first bit is the tag (0 = command, 1 = data) and the next eight bits are the byte, MSB first. The tag appears on rx_is_data.
- R4: Each completed frame gives exactly one rx_valid pulse, and that pulse lasts one system clock cycle.
- R5: Raising csn discards a partial frame without a strobe. The next frame after a partial one decodes correctly. No strobe or read request occurs while csn is high.
- R6: In four-wire framing, suppose a command byte is strobed while cmd_is_read = 1. If dc then goes high at a frame boundary, the block pulses rd_req, loads rd_data and raises sdo_oe. It then drives the byte MSB first on sdo, moving to the next bit on each falling sclk edge.
- R7: In three-wire framing, after a read command, a tag bit of 1 enters the read phase and loads rd_data at once. The falling edge of that tag bit's clock does not shift, so D7 stays on sdo for the first read clock.
- R8: During a read, the eighth falling edge of each byte loads the next rd_data byte and pulses rd_req again. Bytes continue in this way until csn rises.
- R9: A command strobed with cmd_is_read = 0 never starts a read: sdo_oe stays 0, and the data bytes that follow are strobed normally.
- R10: csn going high ends the read phase and drops sdo_oe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the sclk rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| three_wire | input | 1 | Static strap: 0 selects the 8-bit framing with dc, 1 selects the 9-bit framing with an in-band tag |
| sclk | input | 1 | Serial clock |
| sdi | input | 1 | Serial data in |
| csn | input | 1 | Chip select, active low |
| dc | input | 1 | Command/data select, used in four-wire framing |
| cmd_is_read | input | 1 | From host logic, sampled while rx_valid is high for a command: 1 if the command reads a register |
| rd_data | input | 8 | Register byte to send; captured in the cycle that rd_req is set |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for sdo, high only in the read phase with csn low |
| rx_valid | output | 1 | One-cycle strobe for a received byte |
| rx_byte | output | 8 | Received byte |
| rx_is_data | output | 1 | Tag of the received byte: 1 = data, 0 = command |
| rd_req | output | 1 | One-cycle pulse when a read byte is loaded; the host then advances to the next byte |

## Verification
The assertions assume that serial edges are slow compared with the system clock. This keeps strobes and load pulses separated by many cycles. They also assume that csn stays low for a whole transfer, and that the strap and dc change only while sclk is low and between frames. The stimulus uses an sclk half period of eight system clocks and changes sdi and dc only with sclk low. It waits several cycles after csn moves before the next edge, and changes three_wire only while csn is high.

// File: rtl/serial_cmd_rx.sv
module serial_cmd_rx #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         three_wire,
  input  logic         sclk,
  input  logic         sdi,
  input  logic         csn,
  input  logic         dc,
  input  logic         cmd_is_read,
  input  logic [W-1:0] rd_data,
  output logic         sdo,
  output logic         sdo_oe,
  output logic         rx_valid,
  output logic [W-1:0] rx_byte,
  output logic         rx_is_data,
  output logic         rd_req
);
  localparam int CW = $clog2(W + 2);
  localparam int BW = $clog2(W);

  logic [2:0] scl_q;
  logic [1:0] sda_q, cs_q, dc_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_q <= '0;
      sda_q <= '0;
      cs_q  <= 2'b11;
      dc_q  <= '0;
    end else begin
      scl_q <= {scl_q[1:0], sclk};
      sda_q <= {sda_q[0], sdi};
      cs_q  <= {cs_q[0], csn};
      dc_q  <= {dc_q[0], dc};
    end

  wire rise = scl_q[1] & ~scl_q[2];
  wire fall = ~scl_q[1] & scl_q[2];
  wire sel  = ~cs_q[1];
  wire sd   = sda_q[1];
  wire dcs  = dc_q[1];

  logic [CW-1:0] cnt;
  logic [BW-1:0] rd_cnt;
  logic [W-1:0]  shreg, tx;
  logic          flag, armed, rd_phase, skip;

  wire last = three_wire ? (cnt == CW'(W)) : (cnt == CW'(W - 1));
  wire [W-1:0] next_sh = {shreg[W-2:0], sd};

  assign sdo    = tx[W-1];
  assign sdo_oe = rd_phase & sel;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt <= '0; rd_cnt <= '0; shreg <= '0; tx <= '0;
      flag <= 1'b0; armed <= 1'b0; rd_phase <= 1'b0; skip <= 1'b0;
      rx_valid <= 1'b0; rx_byte <= '0; rx_is_data <= 1'b0; rd_req <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      rd_req   <= 1'b0;
      if (rx_valid) armed <= ~rx_is_data & cmd_is_read;
      if (!sel) begin
        cnt <= '0; rd_phase <= 1'b0; armed <= 1'b0; skip <= 1'b0; rd_cnt <= '0;
      end else if (rd_phase) begin
        if (fall) begin
          if (skip) skip <= 1'b0;
          else if (rd_cnt == BW'(W - 1)) begin
            tx <= rd_data; rd_req <= 1'b1; rd_cnt <= '0;
          end else begin
            tx <= {tx[W-2:0], 1'b0}; rd_cnt <= rd_cnt + BW'(1);
          end
        end
      end else if (!three_wire && armed && dcs && cnt == '0) begin
        rd_phase <= 1'b1; tx <= rd_data; rd_req <= 1'b1;
        rd_cnt <= '0; armed <= 1'b0; skip <= 1'b0;
      end else if (rise) begin
        if (three_wire && cnt == '0) begin
          if (armed && sd) begin
            rd_phase <= 1'b1; tx <= rd_data; rd_req <= 1'b1;
            rd_cnt <= '0; armed <= 1'b0; skip <= 1'b1;
          end else begin
            flag <= sd; cnt <= CW'(1); armed <= 1'b0;
          end
        end else begin
          shreg <= next_sh;
          if (last) begin
            rx_valid   <= 1'b1;
            rx_byte    <= next_sh;
            rx_is_data <= three_wire ? flag : dcs;
            cnt        <= '0;
          end else cnt <= cnt + CW'(1);
        end
      end
    end

  p_strobe_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  p_quiet_deselected_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cs_q[1] |=> (!rx_valid && !rd_req));

  p_entry_loads_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdo_oe) |-> rd_req);

  p_read_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_phase |-> !rx_valid);

  p_req_in_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> rd_phase);
endmodule

// File: tb/serial_cmd_rx_test.sv
module serial_cmd_rx_test;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 8;

  logic clk = 0, rst_n = 0, three_wire = 0, sclk = 0, sdi = 0, csn = 1, dc = 0;
  logic [7:0] rd_data;
  logic cmd_is_read, sdo, sdo_oe, rx_valid, rx_is_data, rd_req;
  logic [7:0] rx_byte;

  int checks = 0, errors = 0, n_valid = 0, n_req = 0, rd_base = 0, cyc = 0;
  logic [7:0] last_byte;
  logic last_dat;
  logic [7:0] rd_mem [4] = '{8'hA5, 8'h3C, 8'hE1, 8'h5F};

  assign cmd_is_read = (rx_byte == 8'h2F);
  assign rd_data = rd_mem[2'(n_req - rd_base)];

  serial_cmd_rx uut (.clk(clk), .rst_n(rst_n), .three_wire(three_wire), .sclk(sclk),
    .sdi(sdi), .csn(csn), .dc(dc), .cmd_is_read(cmd_is_read), .rd_data(rd_data),
    .sdo(sdo), .sdo_oe(sdo_oe), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .rx_is_data(rx_is_data), .rd_req(rd_req));

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (rx_valid) begin n_valid++; last_byte = rx_byte; last_dat = rx_is_data; end
    if (rd_req) n_req++;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: actual running expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic waitc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic bit_out(input logic b);
    sdi = b; waitc(HALF); sclk = 1; waitc(HALF); sclk = 0;
  endtask

  task automatic frame(input logic tag, input logic [7:0] b);
    if (three_wire) bit_out(tag); else dc = tag;
    for (int i = 7; i >= 0; i--) bit_out(b[i]);
    waitc(6);
  endtask

  task automatic read_bytes(input int nb, output logic [15:0] got);
    got = '0;
    for (int i = 0; i < nb * 8; i++) begin
      waitc(HALF);
      got = {got[14:0], sdo};
      sclk = 1; waitc(HALF); sclk = 0;
    end
    waitc(6);
  endtask

  localparam logic [9:0] VEC [6] = '{
    {1'b0, 1'b0, 8'h12}, {1'b0, 1'b1, 8'hC3}, {1'b1, 1'b0, 8'h44},
    {1'b1, 1'b1, 8'h80}, {1'b0, 1'b1, 8'h01}, {1'b1, 1'b1, 8'hFE}};

  initial begin
    logic [15:0] got;
    int v0, r0;
    waitc(3);
    chk("R1 rx_valid", rx_valid, 0);
    chk("R1 rd_req", rd_req, 0);
    chk("R1 sdo_oe", sdo_oe, 0);
    rst_n = 1; waitc(3);

    for (int i = 0; i < 6; i++) begin
      three_wire = VEC[i][9]; waitc(4);
      csn = 0; waitc(4);
      v0 = n_valid;
      frame(VEC[i][8], VEC[i][7:0]);
      csn = 1; dc = 0; waitc(6);
      chk(VEC[i][9] ? "R3 byte" : "R2 byte", last_byte, VEC[i][7:0]);
      chk(VEC[i][9] ? "R3 tag" : "R2 tag", last_dat, VEC[i][8]);
      chk("R4 one strobe", n_valid - v0, 1);
    end

    three_wire = 0; waitc(4);
    csn = 0; waitc(4); v0 = n_valid;
    for (int i = 7; i >= 4; i--) bit_out(1'b1);
    waitc(4); csn = 1; waitc(6);
    chk("R5 no strobe on abort", n_valid - v0, 0);
    csn = 0; waitc(4);
    frame(1'b0, 8'h5A);
    csn = 1; waitc(6);
    chk("R5 frame after abort", last_byte, 8'h5A);
    chk("R5 single strobe", n_valid - v0, 1);

    csn = 0; waitc(4);
    frame(1'b0, 8'h2F);
    rd_base = n_req; r0 = n_req;
    dc = 1; waitc(8);
    chk("R6 oe", sdo_oe, 1);
    chk("R6 req", n_req - r0, 1);
    read_bytes(2, got);
    chk("R6 first byte", got[15:8], 8'hA5);
    chk("R8 second byte", got[7:0], 8'h3C);
    chk("R8 reqs", n_req - r0, 3);
    csn = 1; dc = 0; waitc(6);
    chk("R10 oe dropped", sdo_oe, 0);

    three_wire = 1; waitc(4);
    csn = 0; waitc(4);
    frame(1'b0, 8'h2F);
    rd_base = n_req; r0 = n_req;
    bit_out(1'b1); waitc(6);
    chk("R7 oe", sdo_oe, 1);
    read_bytes(1, got);
    chk("R7 byte", got[7:0], 8'hA5);
    csn = 1; waitc(6);
    chk("R10 oe dropped 3w", sdo_oe, 0);

    three_wire = 0; waitc(4);
    csn = 0; waitc(4);
    frame(1'b0, 8'h24);
    r0 = n_req;
    dc = 1; waitc(10);
    chk("R9 no read oe", sdo_oe, 0);
    chk("R9 no req", n_req - r0, 0);
    frame(1'b1, 8'h81);
    chk("R9 data byte", last_byte, 8'h81);
    chk("R9 data tag", last_dat, 1);
    csn = 1; dc = 0; waitc(6);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule